// File: doc/BRIEF.md
# Eight-bit timer with a prescaler shared with the watchdog

This block is an 8-bit up-counter for a small controller core. It counts either the instruction-cycle rate, which it divides down from the core clock by 1, 2, 4 or 8, or edges on an external clock pin. The active edge of that pin is selectable. Each count event passes through a two-stage synchroniser before it reaches the counter. When the counter wraps from FFh to 00h, the block raises a one-cycle overflow pulse, which the interrupt logic can latch.

A single 8-bit prescaler serves either the timer or the watchdog, never both. One option bit decides which of the two owns it. The owner sees its events divided by a ratio picked with a 3-bit tap select. The other side bypasses the prescaler. On the watchdog side, a tick arriving from an external watchdog oscillator becomes a timeout pulse, either directly or after the prescaler.

Software reaches the block through a write port and a read port. Each port has a select input that picks the count register or the option register. A write to the count reloads the counter, clears the prescaler and restarts the synchroniser.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset the count reads 00h, the option register reads 3Fh (all six option bits set), and ovf_pulse and wdt_timeout are low.
- R2: The option register holds six bits: [2:0] tap select, [3] prescaler owned by the watchdog, [4] count on the falling edge of ext_clk, [5] count ext_clk instead of the instruction cycle. It reads back zero-extended, so bits [7:6] of a write are dropped.
- R3: With bit [3] clear, the timer advances once per 2^(tap+1) source events, from 1:2 at tap 0 up to 1:256 at tap 7.
- R4: With bit [3] set, the timer advances once per source event and ignores the tap select. An event raised at clock edge n changes the count at edge n+2.
- R5: A write with wr_sel=0 loads wr_data into the count, clears the prescaler, and blocks increments at the two clock edges that follow.
- R6: An increment from FFh gives 00h, and ovf_pulse is high for exactly the one cycle in which the count first reads 00h.
- R7: The internal source raises one event every 2^cyc_div clock cycles (cyc_div 0..3 gives 1, 2, 4 or 8).
- R8: With bit [5] set, each rising edge of ext_clk is one event when bit [4] is clear, and each falling edge is one event when bit [4] is set. The opposite edge has no effect.
- R9: With bit [3] set, wdt_timeout pulses for one cycle, in the cycle after the clock edge that samples the 2^tap-th wdt_tick since the prescaler was last cleared.
- R10: With bit [3] clear, every wdt_tick produces a wdt_timeout pulse in the following cycle, whatever the tap select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_div | input | 2 | Instruction-cycle division, 2^cyc_div |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 option |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 count, 1 option |
| rd_data | output | 8 | Read data |
| ext_clk | input | 1 | External count clock pin |
| wdt_tick | input | 1 | One-cycle watchdog oscillator tick |
| wdt_timeout | output | 1 | Watchdog timeout pulse |
| ovf_pulse | output | 1 | Counter wrap pulse |

## Verification
The counter is driven at the full instruction rate with the prescaler bypassed, then at the slower division rates. These runs separate the synchroniser latency and the post-write hold from the rate itself. Prescaler ratios 1:2, 1:8 and 1:256 are read at the edges just before and just after an expected step, so an off-by-one tap fails. Pulses on the external pin are checked in both edge polarities, with a count taken after the counted edge and again after the ignored edge. Watchdog ticks are sent with the prescaler owned by the watchdog and with it owned by the timer, and a count-register write partway through a tick sequence shows that the write clears the prescaler.

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer #(
  parameter int DW   = 8,
  parameter int SELW = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_div,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          ext_clk,
  input  logic          wdt_tick,
  output logic          wdt_timeout,
  output logic          ovf_pulse
);
  localparam int PW = 1 << SELW;
  localparam int OW = SELW + 3;

  logic [2:0]    dcnt;
  logic [OW-1:0] opt;
  logic          pin_q;
  logic [PW-1:0] pre_cnt;
  logic [1:0]    sync;
  logic [1:0]    hold;
  logic [DW-1:0] cnt;

  wire [SELW-1:0] ps       = opt[SELW-1:0];
  wire            pre_wdt  = opt[SELW];
  wire            ext_fall = opt[SELW+1];
  wire            ext_src  = opt[SELW+2];

  wire [2:0] dmask  = 3'((4'd1 << cyc_div) - 4'd1);
  wire       cyc_en = (dcnt & dmask) == dmask;

  wire pin_x   = ext_clk ^ ext_fall;
  wire tmr_evt = ext_src ? (pin_x & ~pin_q) : cyc_en;
  wire pre_evt = pre_wdt ? wdt_tick : tmr_evt;

  wire [PW-1:0] wmask = (PW'(1) << ps) - PW'(1);
  wire [PW-1:0] tmask = {wmask[PW-2:0], 1'b1};
  wire hit_w    = &(pre_cnt | ~wmask);
  wire hit_t    = &(pre_cnt | ~tmask);
  wire pre_fire = pre_evt & (pre_wdt ? hit_w : hit_t);

  wire inc_req  = pre_wdt ? tmr_evt : pre_fire;
  wire wdt_next = pre_wdt ? pre_fire : wdt_tick;
  wire tmr_wr   = wr_en & ~wr_sel;
  wire opt_wr   = wr_en & wr_sel;
  wire do_inc   = sync[1] & (hold == 2'd0);

  assign rd_data = rd_sel ? DW'(opt) : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt        <= '0;
      opt         <= '1;
      pin_q       <= 1'b1;
      pre_cnt     <= '0;
      sync        <= '0;
      hold        <= '0;
      cnt         <= '0;
      ovf_pulse   <= 1'b0;
      wdt_timeout <= 1'b0;
    end else begin
      dcnt        <= dcnt + 3'd1;
      pin_q       <= pin_x;
      wdt_timeout <= wdt_next;
      if (opt_wr) opt <= wr_data[OW-1:0];
      if (tmr_wr) begin
        pre_cnt   <= '0;
        sync      <= '0;
        hold      <= 2'd2;
        cnt       <= wr_data;
        ovf_pulse <= 1'b0;
      end else begin
        if (pre_evt) pre_cnt <= pre_cnt + PW'(1);
        sync      <= {sync[0], inc_req};
        if (hold != 2'd0) hold <= hold - 2'd1;
        ovf_pulse <= do_inc && (cnt == '1);
        if (do_inc) cnt <= cnt + DW'(1);
      end
    end
  end
endmodule

// File: rtl/shared_prescale_timer_chk.sv
module shared_prescale_timer_chk #(
  parameter int DW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] cnt,
  input logic          ovf_pulse,
  input logic          wdt_timeout,
  input logic          wdt_tick
);
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> cnt == $past(wr_data));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && !wr_sel) && !wr_en) |=> $stable(cnt));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> (cnt == $past(cnt) || cnt == $past(cnt) + DW'(1)));

  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt == '0);

  a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> $past(wdt_tick));
endmodule

bind shared_prescale_timer shared_prescale_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt(cnt), .ovf_pulse(ovf_pulse), .wdt_timeout(wdt_timeout), .wdt_tick(wdt_tick)
);

// File: tb/shared_prescale_timer_test.sv
module shared_prescale_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cyc_div = 2'd0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ext_clk = 1'b0, wdt_tick = 1'b0;
  logic       wdt_timeout, ovf_pulse;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [7:0] exp; string req; } item_t;
  item_t q[$];

  shared_prescale_timer uut (
    .clk(clk), .rst_n(rst_n), .cyc_div(cyc_div), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ext_clk(ext_clk),
    .wdt_tick(wdt_tick), .wdt_timeout(wdt_timeout), .ovf_pulse(ovf_pulse)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      case (it.kind)
        0:       got = rd_data;
        1:       got = {7'd0, ovf_pulse};
        default: got = {7'd0, wdt_timeout};
      endcase
      nchk++;
      if (got !== it.exp) begin
        nerr++;
        $display("FAIL %s: got %0h expected %0h", it.req, got, it.exp);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic settle(); @(negedge clk); #1; endtask

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic chk_rd(logic sel, logic [7:0] exp, string req);
    rd_sel = sel;
    push(0, exp, req);
    settle();
    rd_sel = 1'b0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic ratio_run(logic [2:0] ps, int n);
    wr(1'b1, {5'd0, ps});
    wr(1'b0, 8'h00);
    for (int t = 0; t < n + 1; t++) tick();
    chk_rd(1'b0, 8'h00, "R3 before step");
    tick();
    chk_rd(1'b0, 8'h01, "R3 first step");
    for (int t = 0; t < n; t++) tick();
    chk_rd(1'b0, 8'h02, "R3 second step");
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1;
    repeat (3) tick();
    ext_clk = 1'b0;
    repeat (3) tick();
  endtask

  task automatic wdt_pulse(logic exp, string req);
    wdt_tick = 1'b1;
    tick();
    wdt_tick = 1'b0;
    push(2, {7'd0, exp}, req);
    settle();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk_rd(1'b0, 8'h00, "R1 count");
    chk_rd(1'b1, 8'h3F, "R1 option");
    push(1, 8'h00, "R1 ovf");
    push(2, 8'h00, "R1 wdt");
    settle();

    wr(1'b1, 8'hFF);
    chk_rd(1'b1, 8'h3F, "R2 upper bits dropped");
    wr(1'b1, 8'h0F);
    chk_rd(1'b1, 8'h0F, "R2 readback");

    wr(1'b0, 8'h10);
    tick(); chk_rd(1'b0, 8'h10, "R5 hold edge 1");
    tick(); chk_rd(1'b0, 8'h10, "R5 hold edge 2");
    tick(); chk_rd(1'b0, 8'h11, "R4 first increment");
    tick(); chk_rd(1'b0, 8'h12, "R4 bypass rate");

    wr(1'b0, 8'hFE);
    repeat (3) tick();
    chk_rd(1'b0, 8'hFF, "R6 at FF");
    tick();
    rd_sel = 1'b0;
    push(0, 8'h00, "R6 wrap value");
    push(1, 8'h01, "R6 pulse high");
    settle();
    tick();
    push(0, 8'h01, "R6 after wrap");
    push(1, 8'h00, "R6 pulse one cycle");
    settle();

    ratio_run(3'd0, 2);
    ratio_run(3'd2, 8);
    ratio_run(3'd7, 256);

    wr(1'b1, 8'h0F);
    cyc_div = 2'd1;
    repeat (16) tick();
    settle(); c0 = rd_data;
    repeat (20) tick();
    chk_rd(1'b0, c0 + 8'd10, "R7 divide by 2");
    cyc_div = 2'd3;
    repeat (16) tick();
    settle(); c0 = rd_data;
    repeat (40) tick();
    chk_rd(1'b0, c0 + 8'd5, "R7 divide by 8");
    cyc_div = 2'd0;

    wr(1'b1, 8'h28);
    wr(1'b0, 8'h00);
    repeat (2) tick();
    for (int i = 0; i < 3; i++) begin
      ext_clk = 1'b1;
      repeat (3) tick();
      chk_rd(1'b0, 8'(i + 1), "R8 rising counted");
      ext_clk = 1'b0;
      repeat (3) tick();
      chk_rd(1'b0, 8'(i + 1), "R8 falling ignored");
    end

    wr(1'b1, 8'h38);
    wr(1'b0, 8'h40);
    repeat (2) tick();
    ext_clk = 1'b1;
    repeat (3) tick();
    chk_rd(1'b0, 8'h40, "R8 rising ignored in falling mode");
    ext_clk = 1'b0;
    repeat (3) tick();
    chk_rd(1'b0, 8'h41, "R8 falling counted");

    wr(1'b1, 8'h20);
    wr(1'b0, 8'h00);
    repeat (2) tick();
    ext_pulse();
    chk_rd(1'b0, 8'h00, "R3 external 1:2 first edge");
    repeat (3) ext_pulse();
    chk_rd(1'b0, 8'h02, "R3 external 1:2 four edges");

    wr(1'b1, 8'h0A);
    wr(1'b0, 8'h00);
    for (int i = 0; i < 8; i++) wdt_pulse((i % 4) == 3, "R9 watchdog 1:4");

    wr(1'b1, 8'h08);
    wdt_pulse(1'b1, "R9 watchdog 1:1");
    push(2, 8'h00, "R9 no tick no timeout");
    settle();

    wr(1'b1, 8'h07);
    wdt_pulse(1'b1, "R10 raw tick");
    wdt_pulse(1'b1, "R10 raw tick again");

    wr(1'b1, 8'h0A);
    wr(1'b0, 8'h00);
    for (int i = 0; i < 3; i++) wdt_pulse(1'b0, "R5 ticks before clear");
    wr(1'b0, 8'h00);
    for (int i = 0; i < 3; i++) wdt_pulse(1'b0, "R5 prescaler cleared");
    wdt_pulse(1'b1, "R5 fourth tick after clear");

    tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule